// File: doc/BRIEF.md
# Flow-Through Synchronous Burst SRAM

This block models a small synchronous static RAM whose read path has no output register. Address, data, chip enables, strobes, advance and write controls are captured on the rising clock edge. The word at the captured address appears on `rdata` during the following cycle. A burst starts when either of two address strobes loads an external address: a host-side strobe or a controller-side strobe. After that, the two lowest address bits come from an internal 2-bit counter. The counter steps only on edges where the advance input is low, and it follows either a linear or an interleaved order.

Writes can be enabled byte by byte, through a byte-write enable together with per-byte selects. A separate all-bytes write enable overrides both of those. The output enable and the sleep input act without waiting for a clock. The block has no bidirectional pin. `rdata_oe` marks the cycles in which a board-level data bus would be driven, and a wrapper turns it into a tri-state enable.

Top module: `fsb_sram`

## Requirements
- R1: An access starts only when a strobe is seen with `ce_a_n`=0, `ce_b`=1 and `ce_c_n`=0. A strobe seen with any enable in its inactive state deselects the device.
- R2: `strobe_host_n` is ignored on an edge where `ce_a_n`=1, and the burst state stays unchanged. `strobe_ctrl_n` is not gated this way.
- R3: A strobe loads `addr` and clears the burst count. The word at that address is on `rdata` during the cycle after the loading edge. A new address may be loaded on every edge.
- R4: The burst count steps on an edge only when `adv_n`=0 and no strobe is taken. Otherwise the address holds. The upper address bits never change within a burst.
- R5: With `lin_order`=1 the low two address bits are (loaded value + count) mod 4, and they wrap after four steps.
- R6: With `lin_order`=0 the low two address bits are the loaded value XOR the count.
- R7: Byte i, which is `wdata[8i+7:8i]`, is written when `byte_we_n`=0 and `byte_sel_n[i]`=0. Byte selects have no effect while `byte_we_n`=1.
- R8: `all_we_n`=0 writes every byte, whatever `byte_we_n` and `byte_sel_n` are.
- R9: A write goes to the address in effect after its edge: the loaded address on a strobe edge, the stepped address on an advance edge, and the held address otherwise.
- R10: `rdata_oe` is 1 only when `oe_n`=0, `sleep`=0, the device is selected and the last edge did not write. `oe_n` and `sleep` act without a clock edge.
- R11: Edges seen while `sleep`=1 change nothing. There is no write, no load, no step and no deselect, and the contents are kept.
- R12: After reset the device is deselected, so `rdata_oe`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_a_n | input | 1 | Chip enable A, active low; also gates the host strobe |
| ce_b | input | 1 | Chip enable B, active high |
| ce_c_n | input | 1 | Chip enable C, active low |
| strobe_host_n | input | 1 | Host-side address strobe, active low |
| strobe_ctrl_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| lin_order | input | 1 | 1 = linear burst order, 0 = interleaved |
| addr | input | ADDR_W | External word address |
| byte_we_n | input | 1 | Byte-write enable, active low |
| byte_sel_n | input | NBYTES | Per-byte selects, active low |
| all_we_n | input | 1 | All-bytes write enable, active low |
| oe_n | input | 1 | Output enable, active low, acts without a clock edge |
| sleep | input | 1 | Sleep, active high, acts without a clock edge |
| wdata | input | NBYTES*BYTE_W | Write data |
| rdata | output | NBYTES*BYTE_W | Flow-through read data |
| rdata_oe | output | 1 | Read data is being driven |

## Verification
The hardest state to reach from the ports is a sleep period that falls in the middle of a burst, while strobes, writes and advances keep arriving. Only the data that reappears after wake-up shows whether any of them leaked through. The bench parks a burst on a known word, raises sleep and applies a write strobe to another word plus an advance. It then drops sleep and checks that the old word is still presented and that the target word is untouched. A second subtle case is a host strobe with `ce_a_n` high arriving together with a controller strobe. The bench drives that combination and checks that the result is a deselect rather than a load.

// File: rtl/fsb_pkg.sv
package fsb_pkg;

  typedef enum logic [2:0] {
    ACT_IDLE,
    ACT_DESEL,
    ACT_LOAD,
    ACT_STEP,
    ACT_HOLD
  } fsb_act_e;

  // Low two address bits for a burst position
  function automatic logic [1:0] burst_lo(input logic [1:0] base,
                                          input logic [1:0] cnt,
                                          input logic       lin);
    return lin ? (base + cnt) : (base ^ cnt);
  endfunction

endpackage

// File: rtl/fsb_ctrl.sv
module fsb_ctrl
  import fsb_pkg::*;
#(
  parameter int NBYTES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_a_n,
  input  logic              ce_b,
  input  logic              ce_c_n,
  input  logic              strobe_host_n,
  input  logic              strobe_ctrl_n,
  input  logic              adv_n,
  input  logic              sleep,
  input  logic              all_we_n,
  input  logic              byte_we_n,
  input  logic [NBYTES-1:0] byte_sel_n,
  output fsb_act_e          act,
  output logic [NBYTES-1:0] wr_be,
  output logic              sel_q,
  output logic              wr_q
);

  logic host_go, go, sel_now, access;

  assign host_go = !strobe_host_n && !ce_a_n;
  assign go      = host_go || !strobe_ctrl_n;
  assign sel_now = !ce_a_n && ce_b && !ce_c_n;

  always_comb begin
    if (sleep)      act = ACT_IDLE;
    else if (go)    act = sel_now ? ACT_LOAD : ACT_DESEL;
    else if (sel_q) act = adv_n ? ACT_HOLD : ACT_STEP;
    else            act = ACT_IDLE;
  end

  assign access = (act == ACT_LOAD) || (act == ACT_STEP) || (act == ACT_HOLD);

  for (genvar i = 0; i < NBYTES; i++) begin : g_be
    assign wr_be[i] = access && (!all_we_n || (!byte_we_n && !byte_sel_n[i]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= 1'b0;
      wr_q  <= 1'b0;
    end else if (!sleep) begin
      if (act == ACT_LOAD)       sel_q <= 1'b1;
      else if (act == ACT_DESEL) sel_q <= 1'b0;
      wr_q <= |wr_be;
    end
  end

  // R1
  desel_chk: assert property (@(posedge clk) disable iff (rst)
    (go && !sel_now && !sleep) |=> !sel_q);

  // R2
  host_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (!strobe_host_n && ce_a_n && strobe_ctrl_n && !sleep) |=> $stable(sel_q));

  // R11
  sleep_hold_chk: assert property (@(posedge clk) disable iff (rst)
    sleep |=> ($stable(sel_q) && $stable(wr_q)));

endmodule

// File: rtl/fsb_burst.sv
module fsb_burst
  import fsb_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  fsb_act_e          act,
  input  logic              lin_order,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [ADDR_W-1:0] wr_addr
);

  logic [ADDR_W-1:0] base_q;
  logic [1:0]        cnt_q;
  logic [1:0]        cnt_nx;

  assign cnt_nx   = cnt_q + 2'd1;
  assign cur_addr = {base_q[ADDR_W-1:2], burst_lo(base_q[1:0], cnt_q, lin_order)};

  always_comb begin
    case (act)
      ACT_LOAD: wr_addr = addr_in;
      ACT_STEP: wr_addr = {base_q[ADDR_W-1:2], burst_lo(base_q[1:0], cnt_nx, lin_order)};
      default:  wr_addr = cur_addr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      cnt_q  <= 2'd0;
    end else if (act == ACT_LOAD) begin
      base_q <= addr_in;
      cnt_q  <= 2'd0;
    end else if (act == ACT_STEP) begin
      cnt_q  <= cnt_nx;
    end
  end

  // R3
  load_chk: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_LOAD) |=> (cnt_q == 2'd0 && base_q == $past(addr_in)));

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_HOLD) |=> ($stable(cnt_q) && $stable(base_q)));

  // R4
  step_chk: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_STEP) |=> (cnt_q == $past(cnt_q) + 2'd1 && $stable(base_q)));

endmodule

// File: rtl/fsb_array.sv
module fsb_array #(
  parameter int ADDR_W = 6,
  parameter int NBYTES = 2,
  parameter int BYTE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NBYTES-1:0]        we,
  input  logic [ADDR_W-1:0]        waddr,
  input  logic [NBYTES*BYTE_W-1:0] wdata,
  input  logic [ADDR_W-1:0]        raddr,
  output logic [NBYTES*BYTE_W-1:0] rdata
);

  localparam int DEPTH  = 1 << ADDR_W;
  localparam int DATA_W = NBYTES * BYTE_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    for (int b = 0; b < NBYTES; b++) begin
      if (we[b]) mem[waddr][b*BYTE_W +: BYTE_W] <= wdata[b*BYTE_W +: BYTE_W];
    end
  end

  assign rdata = mem[raddr];

  for (genvar i = 0; i < NBYTES; i++) begin : g_chk
    // R7
    byte_store_chk: assert property (@(posedge clk) disable iff (rst)
      we[i] |=> (mem[$past(waddr)][i*BYTE_W +: BYTE_W] == $past(wdata[i*BYTE_W +: BYTE_W])));
  end

endmodule

// File: rtl/fsb_sram.sv
module fsb_sram
  import fsb_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int NBYTES = 2,
  parameter int BYTE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     ce_a_n,
  input  logic                     ce_b,
  input  logic                     ce_c_n,
  input  logic                     strobe_host_n,
  input  logic                     strobe_ctrl_n,
  input  logic                     adv_n,
  input  logic                     lin_order,
  input  logic [ADDR_W-1:0]        addr,
  input  logic                     byte_we_n,
  input  logic [NBYTES-1:0]        byte_sel_n,
  input  logic                     all_we_n,
  input  logic                     oe_n,
  input  logic                     sleep,
  input  logic [NBYTES*BYTE_W-1:0] wdata,
  output logic [NBYTES*BYTE_W-1:0] rdata,
  output logic                     rdata_oe
);

  fsb_act_e          act;
  logic [NBYTES-1:0] wr_be;
  logic              sel_q, wr_q;
  logic [ADDR_W-1:0] cur_addr, wr_addr;

  fsb_ctrl #(.NBYTES(NBYTES)) u_ctrl (
    .clk(clk), .rst(rst),
    .ce_a_n(ce_a_n), .ce_b(ce_b), .ce_c_n(ce_c_n),
    .strobe_host_n(strobe_host_n), .strobe_ctrl_n(strobe_ctrl_n),
    .adv_n(adv_n), .sleep(sleep),
    .all_we_n(all_we_n), .byte_we_n(byte_we_n), .byte_sel_n(byte_sel_n),
    .act(act), .wr_be(wr_be), .sel_q(sel_q), .wr_q(wr_q)
  );

  fsb_burst #(.ADDR_W(ADDR_W)) u_burst (
    .clk(clk), .rst(rst), .act(act), .lin_order(lin_order),
    .addr_in(addr), .cur_addr(cur_addr), .wr_addr(wr_addr)
  );

  fsb_array #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_array (
    .clk(clk), .rst(rst), .we(wr_be), .waddr(wr_addr), .wdata(wdata),
    .raddr(cur_addr), .rdata(rdata)
  );

  assign rdata_oe = !oe_n && !sleep && sel_q && !wr_q;

  // R10
  drive_off_chk: assert property (@(posedge clk) disable iff (rst)
    (oe_n || sleep) |-> !rdata_oe);

  // R12
  reset_desel_chk: assert property (@(posedge clk)
    $past(rst) |-> !rdata_oe);

endmodule

// File: tb/fsb_sram_test.sv
`timescale 1ns/1ps
module fsb_sram_test;

  typedef struct packed {
    logic [2:0]  ce;   // {ce_a_n, ce_b, ce_c_n}
    logic [1:0]  stb;  // {strobe_host_n, strobe_ctrl_n}
    logic        adv;  // adv_n
    logic [3:0]  wr;   // {all_we_n, byte_we_n, byte_sel_n[1], byte_sel_n[0]}
    logic [5:0]  a;
    logic [15:0] d;
    logic        eoe;
    logic [15:0] edq;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VEC [NV] = '{
    '{3'b010, 2'b10, 1'b1, 4'b0111, 6'h08, 16'h1111, 1'b0, 16'h0000, 4'd9}, // R9 load+write
    '{3'b010, 2'b11, 1'b0, 4'b0111, 6'h00, 16'h2222, 1'b0, 16'h0000, 4'd9}, // step write
    '{3'b010, 2'b11, 1'b0, 4'b0111, 6'h00, 16'h3333, 1'b0, 16'h0000, 4'd9},
    '{3'b010, 2'b11, 1'b0, 4'b0111, 6'h00, 16'h4444, 1'b0, 16'h0000, 4'd9},
    '{3'b010, 2'b11, 1'b0, 4'b0111, 6'h00, 16'h5555, 1'b0, 16'h0000, 4'd5}, // R5 wrap to 08
    '{3'b010, 2'b01, 1'b1, 4'b1111, 6'h09, 16'h0000, 1'b1, 16'h2222, 4'd3}, // R3
    '{3'b010, 2'b11, 1'b0, 4'b1111, 6'h00, 16'h0000, 1'b1, 16'h3333, 4'd4}, // R4 step
    '{3'b010, 2'b11, 1'b1, 4'b1111, 6'h00, 16'h0000, 1'b1, 16'h3333, 4'd4}, // R4 hold
    '{3'b010, 2'b11, 1'b0, 4'b1111, 6'h00, 16'h0000, 1'b1, 16'h4444, 4'd5},
    '{3'b010, 2'b11, 1'b0, 4'b1111, 6'h00, 16'h0000, 1'b1, 16'h5555, 4'd5}, // wrap
    '{3'b010, 2'b10, 1'b1, 4'b1010, 6'h0A, 16'hABCD, 1'b0, 16'h0000, 4'd7}, // R7 byte 0
    '{3'b010, 2'b11, 1'b1, 4'b1111, 6'h00, 16'h0000, 1'b1, 16'h33CD, 4'd7},
    '{3'b010, 2'b10, 1'b1, 4'b1101, 6'h0A, 16'h0000, 1'b1, 16'h33CD, 4'd7}, // sel w/o enable
    '{3'b010, 2'b10, 1'b1, 4'b0001, 6'h0C, 16'hBEEF, 1'b0, 16'h0000, 4'd8}, // R8
    '{3'b010, 2'b11, 1'b1, 4'b1111, 6'h00, 16'h0000, 1'b1, 16'hBEEF, 4'd8},
    '{3'b010, 2'b01, 1'b1, 4'b1111, 6'h08, 16'h0000, 1'b1, 16'h5555, 4'd3}, // back to back
    '{3'b010, 2'b01, 1'b1, 4'b1111, 6'h09, 16'h0000, 1'b1, 16'h2222, 4'd3},
    '{3'b010, 2'b10, 1'b1, 4'b1111, 6'h0B, 16'h0000, 1'b1, 16'h4444, 4'd3},
    '{3'b110, 2'b01, 1'b1, 4'b1111, 6'h08, 16'h0000, 1'b1, 16'h4444, 4'd2}, // R2 ignored
    '{3'b110, 2'b00, 1'b1, 4'b1111, 6'h08, 16'h0000, 1'b0, 16'h0000, 4'd2}, // ctrl deselects
    '{3'b010, 2'b10, 1'b1, 4'b1111, 6'h08, 16'h0000, 1'b1, 16'h5555, 4'd1}, // R1
    '{3'b000, 2'b10, 1'b1, 4'b1111, 6'h08, 16'h0000, 1'b0, 16'h0000, 4'd1},
    '{3'b011, 2'b01, 1'b1, 4'b1111, 6'h09, 16'h0000, 1'b0, 16'h0000, 4'd1},
    '{3'b010, 2'b01, 1'b1, 4'b1111, 6'h09, 16'h0000, 1'b1, 16'h2222, 4'd1}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ce_a_n = 1'b1, ce_b = 1'b0, ce_c_n = 1'b1;
  logic        strobe_host_n = 1'b1, strobe_ctrl_n = 1'b1, adv_n = 1'b1;
  logic        lin_order = 1'b1;
  logic [5:0]  addr = '0;
  logic        byte_we_n = 1'b1, all_we_n = 1'b1;
  logic [1:0]  byte_sel_n = 2'b11;
  logic        oe_n = 1'b0, sleep = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        rdata_oe;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  fsb_sram uut (
    .clk(clk), .rst(rst), .ce_a_n(ce_a_n), .ce_b(ce_b), .ce_c_n(ce_c_n),
    .strobe_host_n(strobe_host_n), .strobe_ctrl_n(strobe_ctrl_n), .adv_n(adv_n),
    .lin_order(lin_order), .addr(addr), .byte_we_n(byte_we_n),
    .byte_sel_n(byte_sel_n), .all_we_n(all_we_n), .oe_n(oe_n), .sleep(sleep),
    .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe)
  );

  task automatic check(input logic eoe, input logic [15:0] edq, input int req);
    n_cmp++;
    if (rdata_oe !== eoe) begin
      n_bad++;
      $display("FAIL R%0d: rdata_oe=%b expected %b", req, rdata_oe, eoe);
    end else if (eoe && rdata !== edq) begin
      n_bad++;
      $display("FAIL R%0d: rdata=%h expected %h", req, rdata, edq);
    end
  endtask

  // drive at falling edge, let one rising edge pass, settle away from it
  task automatic cyc(input logic [2:0] ce, input logic [1:0] stb, input logic adv,
                     input logic [3:0] wr, input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    {ce_a_n, ce_b, ce_c_n} = ce;
    {strobe_host_n, strobe_ctrl_n} = stb;
    adv_n = adv;
    {all_we_n, byte_we_n, byte_sel_n} = wr;
    addr = a;
    wdata = d;
    @(posedge clk);
    #2;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: run did not end, actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check(1'b0, 16'h0, 12); // R12 reset state
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      cyc(VEC[i].ce, VEC[i].stb, VEC[i].adv, VEC[i].wr, VEC[i].a, VEC[i].d);
      check(VEC[i].eoe, VEC[i].edq, int'(VEC[i].req));
    end

    // Fill 0x10..0x13 with 0x1000+address
    for (int k = 0; k < 4; k++)
      cyc(3'b010, 2'b10, 1'b1, 4'b0111, 6'h10 + 6'(k), 16'h1000 + 16'(6'h10 + 6'(k)));

    // R5 linear from 0x11: 11,12,13,10, wrap 11
    lin_order = 1'b1;
    cyc(3'b010, 2'b01, 1'b1, 4'b1111, 6'h11, 16'h0); check(1'b1, 16'h1011, 5);
    cyc(3'b010, 2'b11, 1'b0, 4'b1111, 6'h00, 16'h0); check(1'b1, 16'h1012, 5);
    cyc(3'b010, 2'b11, 1'b0, 4'b1111, 6'h00, 16'h0); check(1'b1, 16'h1013, 5);
    cyc(3'b010, 2'b11, 1'b0, 4'b1111, 6'h00, 16'h0); check(1'b1, 16'h1010, 5);
    cyc(3'b010, 2'b11, 1'b0, 4'b1111, 6'h00, 16'h0); check(1'b1, 16'h1011, 5);

    // R6 interleaved from 0x11: 11,10,13,12
    lin_order = 1'b0;
    cyc(3'b010, 2'b01, 1'b1, 4'b1111, 6'h11, 16'h0); check(1'b1, 16'h1011, 6);
    cyc(3'b010, 2'b11, 1'b0, 4'b1111, 6'h00, 16'h0); check(1'b1, 16'h1010, 6);
    cyc(3'b010, 2'b11, 1'b0, 4'b1111, 6'h00, 16'h0); check(1'b1, 16'h1013, 6);
    cyc(3'b010, 2'b11, 1'b0, 4'b1111, 6'h00, 16'h0); check(1'b1, 16'h1012, 6);
    lin_order = 1'b1;

    // R11 sleep mid-burst
    cyc(3'b010, 2'b01, 1'b1, 4'b1111, 6'h0A, 16'h0); check(1'b1, 16'h33CD, 11);
    @(negedge clk);
    sleep = 1'b1;
    #1 check(1'b0, 16'h0, 10); // R10 sleep drops drive at once
    cyc(3'b010, 2'b10, 1'b1, 4'b0111, 6'h0C, 16'h0000);
    cyc(3'b010, 2'b11, 1'b0, 4'b0111, 6'h00, 16'h0000);
    @(negedge clk);
    sleep = 1'b0;
    {strobe_host_n, strobe_ctrl_n, adv_n} = 3'b111;
    {all_we_n, byte_we_n, byte_sel_n} = 4'b1111;
    #1 check(1'b1, 16'h33CD, 11); // no load, no step during sleep
    cyc(3'b010, 2'b01, 1'b1, 4'b1111, 6'h0C, 16'h0); check(1'b1, 16'hBEEF, 11);

    // R10 output enable acts without clock
    @(negedge clk);
    oe_n = 1'b1;
    #1 check(1'b0, 16'h0, 10);
    oe_n = 1'b0;
    #1 check(1'b1, 16'hBEEF, 10);

    // R12 reset mid-run deselects
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #2 check(1'b0, 16'h0, 12);
    rst = 1'b0;

    finish_run();
  end

endmodule